// File: doc/BRIEF.md
# Priority Watermark Transmit Credit Allocator

This block guards a small shared pool of transmit packet buffers. Each cycle it may receive one packet request carrying a two-bit priority and a flag that marks the packet as a response. It answers in the same cycle with either a grant or a deny. A granted request takes one buffer. A release strobe returns one buffer once a packet has been drained onto the link. The number of free buffers is always visible on an output.

Admission is tiered. Every priority has a watermark: the number of buffers that must stay free after low-priority traffic stops. A request is admitted only while the free count is strictly greater than the watermark of its effective priority. A response packet is promoted one priority level above the level it carries, up to the top level. The top level has a fixed watermark of zero. Low-priority requests therefore can never drain the last few buffers, and a buffer remains reachable for responses. The watermarks of the three lower levels can be rewritten through a simple write port.

Internally a pool state machine tracks occupancy in three states. `ST_FULL` means every buffer is free. `ST_PART` means some but not all are free. `ST_EMPTY` means none is free. The transitions are:
- *take-first*: `ST_FULL` to `ST_PART`.
- *return-last*: `ST_PART` to `ST_FULL`.
- *take-last*: `ST_PART` to `ST_EMPTY`.
- *return-first*: `ST_EMPTY` to `ST_PART`.

A release that arrives in `ST_FULL` is discarded.

Top module: `credit_alloc`

## Requirements
- R1: After reset the free count is 8 (the pool size), grant, deny and the error flag are 0, and the watermarks of priorities 0, 1 and 2 are 3, 2 and 1.
- R2: While req_valid is high exactly one of grant and deny is high in the same cycle. Grant is high exactly when the free count is strictly greater than the watermark of the effective priority. With req_valid low both are low.
- R3: With default watermarks, a priority-0 request is denied at 3 or fewer free buffers, priority 1 at 2 or fewer, and priority 2 at 1 or fewer. Priority 3 has a fixed watermark of 0 and may take the last buffer.
- R4: A request with req_resp high uses effective priority req_prio+1, and priority 3 stays at 3.
- R5: A grant with no release lowers the free count by one on the next clock edge. A deny leaves the count unchanged.
- R6: A release while fewer than 8 buffers are free raises the count by one on the next edge. A grant and an accepted release in the same cycle leave the count unchanged.
- R7: A release while all 8 buffers are free does not change the count and sets rel_err on the next edge. Once set, rel_err stays high until reset.
- R8: When wm_we is high and wm_sel is 0, 1 or 2, the watermark of that priority takes wm_data from the next cycle on. A write with wm_sel equal to 3 has no effect, so priority 3 still takes the last buffer.
- R9: The free count never exceeds 8. At a free count of 0 every request is denied.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Packet request strobe |
| req_prio | input | 2 | Request priority, 0 lowest, 3 highest |
| req_resp | input | 1 | Request is a response packet (promoted one level) |
| rel_valid | input | 1 | Buffer release strobe |
| wm_we | input | 1 | Watermark write enable |
| wm_sel | input | 2 | Priority whose watermark is written |
| wm_data | input | 4 | New watermark value |
| grant | output | 1 | Request admitted this cycle |
| deny | output | 1 | Request refused this cycle |
| free_cnt | output | 4 | Current number of free buffers |
| rel_err | output | 1 | Sticky flag: release seen with the pool full |

## Verification
Directed sequences first drain the pool with one priority at a time. This shows that each level stops at its own threshold, separating an off-by-one compare from a correct one. It also shows that priority 3 alone reaches zero. Response requests are then issued at free counts where promoted and unpromoted priorities disagree, which exposes a missing or doubled promotion. Same-cycle grant and release, a release at full pool, and watermark writes, including one aimed at priority 3, cover the count arithmetic and the ignored inputs. A long seeded random mix of requests, releases and watermark writes then keeps the pool moving through all three occupancy states against a reference model.

// File: rtl/credit_pkg.sv
package credit_pkg;

    typedef enum logic [1:0] {
        ST_FULL  = 2'd0,
        ST_PART  = 2'd1,
        ST_EMPTY = 2'd2
    } pool_st_e;

    // Responses climb one priority level, saturating at the top level.
    function automatic logic [1:0] eff_prio(input logic [1:0] prio, input logic is_resp);
        return (is_resp && prio != 2'd3) ? prio + 2'd1 : prio;
    endfunction

endpackage

// File: rtl/credit_wm_regs.sv
module credit_wm_regs #(
    parameter int CW  = 4,
    parameter int WM0 = 3,
    parameter int WM1 = 2,
    parameter int WM2 = 1
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                wm_we,
    input  logic [1:0]          wm_sel,
    input  logic [CW-1:0]       wm_data,
    output logic [3:0][CW-1:0]  wm_q
);
    localparam int NPROG = 3;

    for (genvar i = 0; i < NPROG; i++) begin : g_wm
        localparam int DEFV = (i == 0) ? WM0 : (i == 1) ? WM1 : WM2;
        logic [CW-1:0] wm_r;
        always_ff @(posedge clk) begin
            if (!rst_n)
                wm_r <= CW'(DEFV);
            else if (wm_we && wm_sel == 2'(i))
                wm_r <= wm_data;
        end
        assign wm_q[i] = wm_r;
    end

    // Top priority is fixed: it may always take the last buffer.
    assign wm_q[3] = '0;

endmodule

// File: rtl/credit_admit.sv
module credit_admit
    import credit_pkg::*;
#(
    parameter int CW = 4
) (
    input  logic                req_valid,
    input  logic [1:0]          req_prio,
    input  logic                req_resp,
    input  logic [CW-1:0]       free_cnt,
    input  logic [3:0][CW-1:0]  wm_q,
    output logic                grant,
    output logic                deny
);
    logic [1:0]    level;
    logic [CW-1:0] thresh;
    logic          room;

    always_comb begin
        level  = eff_prio(req_prio, req_resp);
        thresh = wm_q[level];
        room   = free_cnt > thresh;
        grant  = req_valid && room;
        deny   = req_valid && !room;
    end

endmodule

// File: rtl/credit_pool.sv
module credit_pool
    import credit_pkg::*;
#(
    parameter int POOL = 8,
    parameter int CW   = 4
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          take,
    input  logic          rel_valid,
    output logic [CW-1:0] free_cnt,
    output logic          rel_err
);
    localparam logic [CW-1:0] FULLV = CW'(POOL);

    pool_st_e      state, nxt_state;
    logic [CW-1:0] cnt, nxt_cnt;
    logic          err_r;
    logic          inc;

    always_comb begin
        inc     = rel_valid && (state != ST_FULL);
        nxt_cnt = cnt;
        if (inc && !take)
            nxt_cnt = cnt + CW'(1);
        else if (take && !inc)
            nxt_cnt = cnt - CW'(1);
    end

    always_comb begin
        nxt_state = state;
        unique case (state)
            ST_FULL: begin                      // take-first
                if (nxt_cnt != FULLV)
                    nxt_state = (nxt_cnt == '0) ? ST_EMPTY : ST_PART;
            end
            ST_PART: begin                      // return-last / take-last
                if (nxt_cnt == FULLV)
                    nxt_state = ST_FULL;
                else if (nxt_cnt == '0)
                    nxt_state = ST_EMPTY;
            end
            ST_EMPTY: begin                     // return-first
                if (nxt_cnt != '0)
                    nxt_state = (nxt_cnt == FULLV) ? ST_FULL : ST_PART;
            end
            default: nxt_state = ST_FULL;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state <= ST_FULL;
            cnt   <= FULLV;
            err_r <= 1'b0;
        end else begin
            state <= nxt_state;
            cnt   <= nxt_cnt;
            if (rel_valid && state == ST_FULL)
                err_r <= 1'b1;
        end
    end

    always_comb begin
        free_cnt = cnt;
        rel_err  = err_r;
    end

endmodule

// File: rtl/credit_alloc.sv
module credit_alloc #(
    parameter int  POOL = 8,
    parameter int  WM0  = 3,
    parameter int  WM1  = 2,
    parameter int  WM2  = 1,
    localparam int CW   = $clog2(POOL + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          req_valid,
    input  logic [1:0]    req_prio,
    input  logic          req_resp,
    input  logic          rel_valid,
    input  logic          wm_we,
    input  logic [1:0]    wm_sel,
    input  logic [CW-1:0] wm_data,
    output logic          grant,
    output logic          deny,
    output logic [CW-1:0] free_cnt,
    output logic          rel_err
);
    logic [3:0][CW-1:0] wm_q;

    credit_wm_regs #(.CW(CW), .WM0(WM0), .WM1(WM1), .WM2(WM2)) u_wm (
        .clk     (clk),
        .rst_n   (rst_n),
        .wm_we   (wm_we),
        .wm_sel  (wm_sel),
        .wm_data (wm_data),
        .wm_q    (wm_q)
    );

    credit_admit #(.CW(CW)) u_admit (
        .req_valid (req_valid),
        .req_prio  (req_prio),
        .req_resp  (req_resp),
        .free_cnt  (free_cnt),
        .wm_q      (wm_q),
        .grant     (grant),
        .deny      (deny)
    );

    credit_pool #(.POOL(POOL), .CW(CW)) u_pool (
        .clk       (clk),
        .rst_n     (rst_n),
        .take      (grant),
        .rel_valid (rel_valid),
        .free_cnt  (free_cnt),
        .rel_err   (rel_err)
    );

endmodule

// File: rtl/credit_alloc_chk.sv
module credit_alloc_chk #(
    parameter int POOL = 8,
    parameter int CW   = 4
) (
    input logic          clk,
    input logic          rst_n,
    input logic          req_valid,
    input logic [1:0]    req_prio,
    input logic          rel_valid,
    input logic          grant,
    input logic          deny,
    input logic [CW-1:0] free_cnt,
    input logic          rel_err
);
    localparam logic [CW-1:0] FULLV = CW'(POOL);

    assert_one_answer_R2: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid |-> (grant ^ deny));

    assert_quiet_idle_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !req_valid |-> (!grant && !deny));

    assert_take_dec_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (grant && !rel_valid) |=> (free_cnt == $past(free_cnt) - CW'(1)));

    assert_deny_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (!grant && !rel_valid) |=> $stable(free_cnt));

    assert_ret_inc_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (rel_valid && !grant && free_cnt != FULLV) |=> (free_cnt == $past(free_cnt) + CW'(1)));

    assert_full_rel_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (rel_valid && free_cnt == FULLV) |=> rel_err);

    assert_err_sticky_R7: assert property (@(posedge clk) disable iff (!rst_n)
        rel_err |=> rel_err);

    assert_top_last_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_prio == 2'd3 && free_cnt != '0) |-> grant);

    assert_no_overflow_R9: assert property (@(posedge clk) disable iff (!rst_n)
        free_cnt <= FULLV);

    assert_empty_deny_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && free_cnt == '0) |-> deny);

endmodule

bind credit_alloc credit_alloc_chk #(.POOL(POOL), .CW(CW)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .req_valid (req_valid),
    .req_prio  (req_prio),
    .rel_valid (rel_valid),
    .grant     (grant),
    .deny      (deny),
    .free_cnt  (free_cnt),
    .rel_err   (rel_err)
);

// File: tb/credit_alloc_tb.sv
module credit_alloc_tb;
    localparam int CLK_PERIOD = 10;
    localparam int POOL = 8;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       req_valid = 1'b0;
    logic [1:0] req_prio = '0;
    logic       req_resp = 1'b0;
    logic       rel_valid = 1'b0;
    logic       wm_we = 1'b0;
    logic [1:0] wm_sel = '0;
    logic [3:0] wm_data = '0;
    logic       grant, deny, rel_err;
    logic [3:0] free_cnt;

    int n_checks = 0;
    int n_fail   = 0;
    int wm_m [4];
    int free_m;
    bit err_m;

    always #(CLK_PERIOD/2) clk = ~clk;

    credit_alloc u_dut (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_prio(req_prio),
        .req_resp(req_resp), .rel_valid(rel_valid), .wm_we(wm_we), .wm_sel(wm_sel),
        .wm_data(wm_data), .grant(grant), .deny(deny), .free_cnt(free_cnt),
        .rel_err(rel_err)
    );

    function automatic int level_of(int p, bit r);
        return (r && p != 3) ? p + 1 : p;
    endfunction

    function automatic bit admits(int free, int wm);
        return free > wm;
    endfunction

    task automatic check(bit ok, string tag, int act, int exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d at %0t", tag, act, exp, $time);
        end
    endtask

    task automatic model_reset();
        wm_m[0] = 3; wm_m[1] = 2; wm_m[2] = 1; wm_m[3] = 0;
        free_m = POOL;
        err_m = 1'b0;
    endtask

    // One cycle: drive at negedge, check the combinational answer,
    // then check the registered count and error after the edge.
    task automatic step(bit rv, int p, bit rs, bit rl, bit we, int ws, int wd, string tag);
        bit exp_g;
        @(negedge clk);
        req_valid = rv; req_prio = 2'(p); req_resp = rs; rel_valid = rl;
        wm_we = we; wm_sel = 2'(ws); wm_data = 4'(wd);
        #1;
        exp_g = rv && admits(free_m, wm_m[level_of(p, rs)]);
        check(grant == exp_g, {tag, " grant"}, int'(grant), int'(exp_g));
        check(deny == (rv && !exp_g), {tag, " deny"}, int'(deny), int'(rv && !exp_g));
        @(posedge clk);
        if (rl && free_m == POOL) err_m = 1'b1;
        free_m = free_m + ((rl && free_m != POOL) ? 1 : 0) - (exp_g ? 1 : 0);
        if (we && ws != 3) wm_m[ws] = wd;
        #1;
        check(int'(free_cnt) == free_m, {tag, " free_cnt"}, int'(free_cnt), free_m);
        check(rel_err == err_m, {tag, " rel_err"}, int'(rel_err), int'(err_m));
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog: actual 1 expected 0");
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end

    initial begin
        model_reset();
        repeat (3) @(posedge clk);
        @(negedge clk) rst_n = 1'b1;
        #1;
        // R1: reset state
        check(free_cnt == 4'd8, "R1 free_cnt", int'(free_cnt), 8);
        check(!grant && !deny, "R1 idle answer", int'(grant | deny), 0);
        check(!rel_err, "R1 rel_err", int'(rel_err), 0);

        // R3: drain by priority; each level halts at its own threshold
        for (int i = 0; i < 5; i++) step(1, 0, 0, 0, 0, 0, 0, "R3 p0 fill");
        step(1, 0, 0, 0, 0, 0, 0, "R3 p0 at 3");
        step(1, 1, 0, 0, 0, 0, 0, "R3 p1 at 3");
        step(1, 1, 0, 0, 0, 0, 0, "R3 p1 at 2");
        step(1, 2, 0, 0, 0, 0, 0, "R3 p2 at 2");
        step(1, 2, 0, 0, 0, 0, 0, "R3 p2 at 1");
        step(1, 3, 0, 0, 0, 0, 0, "R3 p3 last");
        step(1, 3, 0, 0, 0, 0, 0, "R9 empty deny");

        // R4: response promotion
        step(0, 0, 0, 1, 0, 0, 0, "R6 release");
        step(1, 2, 1, 0, 0, 0, 0, "R4 p2 resp at 1");
        step(0, 0, 0, 1, 0, 0, 0, "R6 release");
        step(0, 0, 0, 1, 0, 0, 0, "R6 release");
        step(1, 0, 1, 0, 0, 0, 0, "R4 p0 resp at 2");
        step(1, 1, 1, 0, 0, 0, 0, "R4 p1 resp at 2");
        step(1, 3, 1, 0, 0, 0, 0, "R4 p3 resp at 1");

        // R6: grant and release together
        step(0, 0, 0, 1, 0, 0, 0, "R6 release");
        step(1, 3, 0, 1, 0, 0, 0, "R6 grant+release");

        // R7: release at full pool
        for (int i = 0; i < 7; i++) step(0, 0, 0, 1, 0, 0, 0, "R6 refill");
        step(0, 0, 0, 1, 0, 0, 0, "R7 release at full");
        step(1, 0, 0, 0, 0, 0, 0, "R7 sticky");

        // R8: watermark writes
        step(0, 0, 0, 0, 1, 0, 6, "R8 write p0");
        step(1, 0, 0, 0, 0, 0, 0, "R8 p0 at 7");
        step(1, 0, 0, 0, 0, 0, 0, "R8 p0 at 6");
        step(0, 0, 0, 0, 1, 3, 5, "R8 write p3 ignored");
        for (int i = 0; i < 5; i++) step(1, 3, 0, 0, 0, 0, 0, "R8 p3 drain");

        // Seeded random mix
        void'($urandom(32'h5eed_c0de));
        for (int i = 0; i < 3000; i++) begin
            bit rv = ($urandom % 100) < 60;
            bit rl = ($urandom % 100) < 45;
            bit we = ($urandom % 100) < 3;
            step(rv, int'($urandom % 4), bit'($urandom % 2), rl, we,
                 int'($urandom % 4), int'($urandom % 5), "R2 random");
        end

        @(negedge clk);
        req_valid = 0; rel_valid = 0; wm_we = 0;
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end

endmodule